// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry/Exit and Enable Flip-Flop Controller

This block sits beside the instruction sequencer of an 8-bit processor core. It owns the two interrupt-enable flip-flops. The first is the live maskable enable, presented as `intEnable`. The second is a shadow copy, presented as `iff2State`. The block also runs the entry and exit sequences of the non-maskable interrupt. A rising edge on the NMI pin is latched and then taken at the next instruction boundary. The block stalls the core with `busy` and writes the 16-bit resume PC to a byte-wide stack, high byte first, at descending addresses. It then hands the core the fixed restart address and the lowered stack pointer.

The decoder pulses a strobe for each of four instructions it recognises: enable, disable, non-maskable return and maskable return. A return strobe starts a pop sequence. The block reads the low byte at SP and the high byte at SP+1, then loads PC and SP+2. After a non-maskable return, the shadow flip-flop is copied back into the live enable, so the maskable-enable state saved at entry comes back. A maskable return leaves both flip-flops untouched.

Top module: `nmi_iff_ctrl`

## Requirements
- R1: While `rstN` is low and after it, until the first strobe: `intEnable`=0, `iff2State`=0, `busy`=0, and `stkWr`, `stkRd`, `pcLoad` and `spLoad` are all 0.
- R2: When idle, an `eiStb` pulse sets both flip-flops and a `diStb` pulse clears both, visible in the next cycle. If both pulse together, disable wins. Both strobes are ignored while `busy` is high.
- R3: A rising edge of `nmiPin` is latched as pending. A pending request is accepted only in an idle cycle with `instrEnd` high and no return strobe. A level held high produces exactly one acceptance.
- R4: On acceptance, `intEnable` becomes 0. `iff2State` takes the value `intEnable` had, after any enable or disable strobe in the same cycle.
- R5: After acceptance, `busy` is high for cycles 1 to 12. In cycle 8, `stkWr` writes PC[15:8] at SP-1. In cycle 11, `stkWr` writes PC[7:0] at SP-2. PC and SP are `curPc` and `curSp` as sampled at acceptance. `stkAddr` and `stkWrData` are 0 whenever there is no access.
- R6: In cycle 12 of the entry sequence, `pcLoad` outputs `pcNext`=0x0066 and `spLoad` outputs `spNext`=SP-2. `busy` is low in cycle 13. `pcNext` and `spNext` are 0 outside load cycles.
- R7: An idle-cycle `retnStb` or `retiStb` starts a 15-cycle return. `stkRd` reads `stkRdData` at SP in cycle 11 (low byte) and at SP+1 in cycle 14 (high byte). Cycle 15 loads `pcNext`={high,low} and `spNext`=SP+2.
- R8: At the end of a non-maskable return, `intEnable` takes the value of `iff2State`, visible from cycle 16.
- R9: A maskable return changes neither flip-flop.
- R10: NMI edges arriving while busy stay pending and are taken at the first idle boundary. A return strobe in the same cycle as a pending boundary is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiPin | input | 1 | Non-maskable request, rising-edge sensitive |
| instrEnd | input | 1 | High in the last cycle of an instruction |
| eiStb | input | 1 | Enable-interrupts decode strobe |
| diStb | input | 1 | Disable-interrupts decode strobe |
| retnStb | input | 1 | Non-maskable return decode strobe |
| retiStb | input | 1 | Maskable return decode strobe |
| curPc | input | 16 | Resume PC from the core |
| curSp | input | 16 | Current stack pointer from the core |
| busy | output | 1 | Sequence in progress; core stalls |
| pcLoad | output | 1 | Load `pcNext` into PC |
| pcNext | output | 16 | New PC value |
| spLoad | output | 1 | Load `spNext` into SP |
| spNext | output | 16 | New SP value |
| stkAddr | output | 16 | Stack byte address |
| stkWrData | output | 8 | Stack write byte |
| stkWr | output | 1 | Stack write strobe |
| stkRd | output | 1 | Stack read strobe |
| stkRdData | input | 8 | Stack read byte, valid in the cycle `stkRd` is high |
| intEnable | output | 1 | Live maskable enable flip-flop |
| iff2State | output | 1 | Shadow enable flip-flop |

## Verification
A wrong flip-flop value appears at `intEnable` or `iff2State` one cycle after the strobe, acceptance or return load that should have set it. A sequencing fault appears as a stack access in the wrong cycle or at the wrong address. A lost or doubled pending request shows up as `busy` rising one cycle too late or too early after an `instrEnd`. Since every output is compared against a behavioural model on every clock, any of these faults is caught in the cycle it first reaches a port.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_RFETCH1,
    ST_RFETCH2,
    ST_POP_LO,
    ST_POP_HI,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic capture;
    logic nmiTake;
    logic wrHi;
    logic wrLo;
    logic rdLo;
    logic rdHi;
    logic finNmi;
    logic finRet;
    logic restoreIff;
    logic setIff;
    logic clrIff;
  } nmi_strobe_t;

endpackage

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
  import nmi_pkg::*;
#(
  parameter int ACK_CYC   = 5,
  parameter int MEM_CYC   = 3,
  parameter int FETCH_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiPin,
  input  logic        instrEnd,
  input  logic        eiStb,
  input  logic        diStb,
  input  logic        retnStb,
  input  logic        retiStb,
  output logic        busy,
  output nmi_strobe_t strb
);

  localparam int MAX_A = (ACK_CYC > MEM_CYC) ? ACK_CYC : MEM_CYC;
  localparam int MAX_C = (MAX_A > FETCH_CYC) ? MAX_A : FETCH_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  seq_state_t state, stateNxt;
  logic [CNT_W-1:0] cnt, phaseLen;
  logic lastCyc;
  logic isNmi, isRetn;
  logic nmiPrev, nmiPend;
  logic nmiEdge, nmiSeen, retGo, nmiGo, idle;

  assign idle    = (state == ST_IDLE);
  assign nmiEdge = nmiPin & ~nmiPrev;
  assign nmiSeen = nmiPend | nmiEdge;
  assign retGo   = idle & (retnStb | retiStb);
  assign nmiGo   = idle & ~retGo & instrEnd & nmiSeen;

  always_comb begin
    case (state)
      ST_ACK:                              phaseLen = CNT_W'(ACK_CYC);
      ST_PUSH_HI, ST_PUSH_LO,
      ST_POP_LO, ST_POP_HI:                phaseLen = CNT_W'(MEM_CYC);
      ST_RFETCH1, ST_RFETCH2:              phaseLen = CNT_W'(FETCH_CYC);
      default:                             phaseLen = CNT_W'(1);
    endcase
  end

  assign lastCyc = (cnt == phaseLen - CNT_W'(1));

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (retGo)      stateNxt = ST_RFETCH1;
        else if (nmiGo) stateNxt = ST_ACK;
      end
      ST_ACK:     if (lastCyc) stateNxt = ST_PUSH_HI;
      ST_PUSH_HI: if (lastCyc) stateNxt = ST_PUSH_LO;
      ST_PUSH_LO: if (lastCyc) stateNxt = ST_DONE;
      ST_RFETCH1: if (lastCyc) stateNxt = ST_RFETCH2;
      ST_RFETCH2: if (lastCyc) stateNxt = ST_POP_LO;
      ST_POP_LO:  if (lastCyc) stateNxt = ST_POP_HI;
      ST_POP_HI:  if (lastCyc) stateNxt = ST_DONE;
      ST_DONE:    stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isNmi   <= 1'b0;
      isRetn  <= 1'b0;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= (stateNxt != state) ? '0 : cnt + CNT_W'(1);
      nmiPrev <= nmiPin;
      if (nmiGo)        nmiPend <= 1'b0;
      else if (nmiEdge) nmiPend <= 1'b1;
      if (retGo) begin
        isNmi  <= 1'b0;
        isRetn <= retnStb;
      end else if (nmiGo) begin
        isNmi  <= 1'b1;
        isRetn <= 1'b0;
      end
    end
  end

  assign busy = ~idle;

  always_comb begin
    strb            = '0;
    strb.capture    = retGo | nmiGo;
    strb.nmiTake    = nmiGo;
    strb.wrHi       = (state == ST_PUSH_HI) & lastCyc;
    strb.wrLo       = (state == ST_PUSH_LO) & lastCyc;
    strb.rdLo       = (state == ST_POP_LO) & lastCyc;
    strb.rdHi       = (state == ST_POP_HI) & lastCyc;
    strb.finNmi     = (state == ST_DONE) & isNmi;
    strb.finRet     = (state == ST_DONE) & ~isNmi;
    strb.restoreIff = (state == ST_DONE) & ~isNmi & isRetn;
    strb.setIff     = idle & eiStb & ~diStb;
    strb.clrIff     = idle & diStb;
  end

  // R10: an edge seen while a sequence runs must remain pending
  p_edge_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && nmiEdge) |=> nmiPend);

  // R3: a sequence only begins from a boundary or a return strobe
  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(instrEnd) || $past(retnStb) || $past(retiStb)));

endmodule

// File: rtl/nmi_datapath.sv
module nmi_datapath
  import nmi_pkg::*;
#(
  parameter int               BYTE_W = 8,
  parameter int               ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VECTOR = 16'h0066
) (
  input  logic              clk,
  input  logic              rstN,
  input  nmi_strobe_t       strb,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [BYTE_W-1:0] stkRdData,
  output logic [ADDR_W-1:0] stkAddr,
  output logic [BYTE_W-1:0] stkWrData,
  output logic              stkWr,
  output logic              stkRd,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcNext,
  output logic              spLoad,
  output logic [ADDR_W-1:0] spNext,
  output logic              iff1,
  output logic              iff2
);

  logic [ADDR_W-1:0] pcSave, spWork;
  logic [BYTE_W-1:0] loByte, hiByte;
  logic iff1Nxt, iff2Nxt;
  logic hiWritten, loFetched;

  always_comb begin
    iff1Nxt = iff1;
    iff2Nxt = iff2;
    if (strb.clrIff) begin
      iff1Nxt = 1'b0;
      iff2Nxt = 1'b0;
    end else if (strb.setIff) begin
      iff1Nxt = 1'b1;
      iff2Nxt = 1'b1;
    end
    if (strb.nmiTake) begin
      iff2Nxt = iff1Nxt;
      iff1Nxt = 1'b0;
    end
    if (strb.restoreIff) iff1Nxt = iff2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iff1      <= 1'b0;
      iff2      <= 1'b0;
      pcSave    <= '0;
      spWork    <= '0;
      loByte    <= '0;
      hiByte    <= '0;
      hiWritten <= 1'b0;
      loFetched <= 1'b0;
    end else begin
      iff1 <= iff1Nxt;
      iff2 <= iff2Nxt;
      if (strb.capture) begin
        pcSave <= curPc;
        spWork <= curSp;
      end
      if (strb.rdLo) loByte <= stkRdData;
      if (strb.rdHi) hiByte <= stkRdData;
      if (strb.wrHi)      hiWritten <= 1'b1;
      else if (strb.wrLo) hiWritten <= 1'b0;
      if (strb.rdLo)      loFetched <= 1'b1;
      else if (strb.rdHi) loFetched <= 1'b0;
    end
  end

  assign stkWr = strb.wrHi | strb.wrLo;
  assign stkRd = strb.rdLo | strb.rdHi;

  always_comb begin
    stkAddr   = '0;
    stkWrData = '0;
    if (strb.wrHi) begin
      stkAddr   = spWork - ADDR_W'(1);
      stkWrData = pcSave[ADDR_W-1 -: BYTE_W];
    end else if (strb.wrLo) begin
      stkAddr   = spWork - ADDR_W'(2);
      stkWrData = pcSave[BYTE_W-1:0];
    end else if (strb.rdLo) begin
      stkAddr   = spWork;
    end else if (strb.rdHi) begin
      stkAddr   = spWork + ADDR_W'(1);
    end
  end

  assign pcLoad = strb.finNmi | strb.finRet;
  assign spLoad = pcLoad;

  always_comb begin
    pcNext = '0;
    spNext = '0;
    if (strb.finNmi) begin
      pcNext = NMI_VECTOR;
      spNext = spWork - ADDR_W'(2);
    end else if (strb.finRet) begin
      pcNext = {hiByte, loByte};
      spNext = spWork + ADDR_W'(2);
    end
  end

  // R5: low byte is written only after the high byte
  p_push_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |-> hiWritten);

  // R7: high byte is read only after the low byte
  p_pop_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdHi |-> loFetched);

  // R4: acceptance leaves the live enable cleared
  p_nmi_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.nmiTake |=> !iff1);

  // R2: the live enable rises only through enable or non-maskable return
  p_iff1_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iff1) |-> ($past(strb.setIff) || $past(strb.restoreIff)));

  // R9: a maskable return keeps both flip-flops
  p_reti_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finRet && !strb.restoreIff) |=> ($stable(iff1) && $stable(iff2)));

endmodule

// File: rtl/nmi_iff_ctrl.sv
module nmi_iff_ctrl
  import nmi_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter int          ACK_CYC    = 5,
  parameter int          MEM_CYC    = 3,
  parameter int          FETCH_CYC  = 4,
  parameter logic [15:0] NMI_VECTOR = 16'h0066
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          nmiPin,
  input  logic          instrEnd,
  input  logic          eiStb,
  input  logic          diStb,
  input  logic          retnStb,
  input  logic          retiStb,
  input  logic [15:0]   curPc,
  input  logic [15:0]   curSp,
  output logic          busy,
  output logic          pcLoad,
  output logic [15:0]   pcNext,
  output logic          spLoad,
  output logic [15:0]   spNext,
  output logic [15:0]   stkAddr,
  output logic [7:0]    stkWrData,
  output logic          stkWr,
  output logic          stkRd,
  input  logic [7:0]    stkRdData,
  output logic          intEnable,
  output logic          iff2State
);

  localparam int ADDR_W = 2 * BYTE_W;

  nmi_strobe_t strb;

  nmi_ctrl #(
    .ACK_CYC  (ACK_CYC),
    .MEM_CYC  (MEM_CYC),
    .FETCH_CYC(FETCH_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .nmiPin  (nmiPin),
    .instrEnd(instrEnd),
    .eiStb   (eiStb),
    .diStb   (diStb),
    .retnStb (retnStb),
    .retiStb (retiStb),
    .busy    (busy),
    .strb    (strb)
  );

  nmi_datapath #(
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .NMI_VECTOR(NMI_VECTOR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .curPc    (curPc),
    .curSp    (curSp),
    .stkRdData(stkRdData),
    .stkAddr  (stkAddr),
    .stkWrData(stkWrData),
    .stkWr    (stkWr),
    .stkRd    (stkRd),
    .pcLoad   (pcLoad),
    .pcNext   (pcNext),
    .spLoad   (spLoad),
    .spNext   (spNext),
    .iff1     (intEnable),
    .iff2     (iff2State)
  );

endmodule

// File: tb/nmi_iff_ctrl_bench.sv
`timescale 1ns/1ps
module nmi_iff_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nmiPin = 1'b0, instrEnd = 1'b0;
  logic        eiStb = 1'b0, diStb = 1'b0, retnStb = 1'b0, retiStb = 1'b0;
  logic [15:0] curPc = 16'h0000, curSp = 16'h0000;
  logic        busy, pcLoad, spLoad, stkWr, stkRd, intEnable, iff2State;
  logic [15:0] pcNext, spNext, stkAddr;
  logic [7:0]  stkWrData, stkRdData;

  always #2 clk = ~clk;

  logic [7:0] mem [int];

  function automatic logic [7:0] rdMem(logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h5A ^ a[7:0];
  endfunction

  assign stkRdData = rdMem(stkAddr);

  nmi_iff_ctrl u_nmi_iff_ctrl (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .instrEnd(instrEnd),
    .eiStb(eiStb), .diStb(diStb), .retnStb(retnStb), .retiStb(retiStb),
    .curPc(curPc), .curSp(curSp), .busy(busy), .pcLoad(pcLoad),
    .pcNext(pcNext), .spLoad(spLoad), .spNext(spNext), .stkAddr(stkAddr),
    .stkWrData(stkWrData), .stkWr(stkWr), .stkRd(stkRd),
    .stkRdData(stkRdData), .intEnable(intEnable), .iff2State(iff2State)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 entry, 2 return
  int mMode = 0, mCnt = 0;
  bit mIff1 = 0, mIff2 = 0, mPend = 0, mPrev = 0, mRetn = 0;
  int mPc = 0, mSp = 0, mLo = 0, mHi = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mIff1 = 0; mIff2 = 0; mPend = 0; mPrev = 0;
    end else begin
      bit edgeNow;
      edgeNow = nmiPin && !mPrev;
      mPrev = nmiPin;
      if (mMode == 0) begin
        bit a;
        bit b;
        a = mIff1; b = mIff2;
        if (diStb) begin a = 0; b = 0; end
        else if (eiStb) begin a = 1; b = 1; end
        if (retnStb || retiStb) begin
          mMode = 2; mCnt = 1; mSp = int'(curSp); mRetn = retnStb;
          mIff1 = a; mIff2 = b;
          if (edgeNow) mPend = 1;
        end else if (instrEnd && (mPend || edgeNow)) begin
          mMode = 1; mCnt = 1; mPc = int'(curPc); mSp = int'(curSp);
          mIff2 = a; mIff1 = 0; mPend = 0;
        end else begin
          mIff1 = a; mIff2 = b;
          if (edgeNow) mPend = 1;
        end
      end else begin
        if (edgeNow) mPend = 1;
        if (mMode == 2 && mCnt == 11) mLo = int'(rdMem(16'(mSp)));
        if (mMode == 2 && mCnt == 14) mHi = int'(rdMem(16'(mSp + 1)));
        if ((mMode == 1 && mCnt == 12) || (mMode == 2 && mCnt == 15)) begin
          if (mMode == 2 && mRetn) mIff1 = mIff2;
          mMode = 0; mCnt = 0;
        end else mCnt++;
      end
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic eWr, eRd, eLd;
      logic [15:0] eAddr, ePc, eSp;
      logic [7:0] eDat;
      eWr = 0; eRd = 0; eLd = 0; eAddr = 0; eDat = 0; ePc = 0; eSp = 0;
      if (mMode == 1) begin
        if (mCnt == 8)  begin eWr = 1; eAddr = 16'(mSp - 1); eDat = 8'(mPc >> 8); end
        if (mCnt == 11) begin eWr = 1; eAddr = 16'(mSp - 2); eDat = 8'(mPc); end
        if (mCnt == 12) begin eLd = 1; ePc = 16'h0066; eSp = 16'(mSp - 2); end
      end else if (mMode == 2) begin
        if (mCnt == 11) begin eRd = 1; eAddr = 16'(mSp); end
        if (mCnt == 14) begin eRd = 1; eAddr = 16'(mSp + 1); end
        if (mCnt == 15) begin eLd = 1; ePc = {8'(mHi), 8'(mLo)}; eSp = 16'(mSp + 2); end
      end
      chk("R3/R5/R7/R10", "busy", busy, mMode != 0);
      chk("R2/R4/R8/R9", "intEnable", intEnable, mIff1);
      chk("R2/R4/R8/R9", "iff2State", iff2State, mIff2);
      chk("R5", "stkWr", stkWr, eWr);
      chk("R7", "stkRd", stkRd, eRd);
      chk("R5/R7", "stkAddr", stkAddr, eAddr);
      chk("R5", "stkWrData", stkWrData, eDat);
      chk("R6/R7", "pcLoad", pcLoad, eLd);
      chk("R6/R7", "spLoad", spLoad, eLd);
      chk("R6/R7", "pcNext", pcNext, ePc);
      chk("R6/R7", "spNext", spNext, eSp);
      if (stkWr) mem[int'(stkAddr)] = stkWrData;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

  initial begin
    waitCyc(3);
    // R1: reset values
    chk("R1", "intEnable in reset", intEnable, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "stack strobes in reset", {stkWr, stkRd, pcLoad, spLoad}, 0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1", "iff2State after reset", iff2State, 0);

    curPc = 16'h1A45; curSp = 16'h1000;
    // R2: enable, disable, both together
    pulse(eiStb); waitCyc(1);
    pulse(diStb); waitCyc(1);
    eiStb = 1; diStb = 1; waitCyc(1); eiStb = 0; diStb = 0;
    waitCyc(1);
    pulse(eiStb); waitCyc(1);

    // R4: entry with enable set; R3: level held afterwards
    nmiPin = 1; instrEnd = 1; waitCyc(1); instrEnd = 0;
    waitCyc(2);
    pulse(eiStb);                 // R2: ignored while busy
    waitCyc(12);
    instrEnd = 1; waitCyc(1); instrEnd = 0;  // R3: no new edge
    waitCyc(1);
    chk("R3", "no second acceptance", busy, 0);
    nmiPin = 0;

    // R8: non-maskable return restores the live enable
    curSp = 16'h0FFE;
    pulse(retnStb);
    waitCyc(17);
    chk("R8", "enable restored", intEnable, 1);

    // R3: edge without boundary stays pending, taken later
    curPc = 16'h2135; curSp = 16'h3002;
    nmiPin = 1; waitCyc(3);
    instrEnd = 1; waitCyc(1); instrEnd = 0;
    nmiPin = 0;
    waitCyc(14);

    // R9: maskable return keeps enable cleared
    curSp = 16'h3000;
    pulse(retiStb);
    waitCyc(17);
    chk("R9", "enable unchanged", intEnable, 0);

    // R10: edge during busy, then return beside a pending boundary
    pulse(diStb);
    curPc = 16'h4455; curSp = 16'h2000;
    nmiPin = 1; instrEnd = 1; waitCyc(1); instrEnd = 0; nmiPin = 0;
    waitCyc(3);
    nmiPin = 1; waitCyc(2); nmiPin = 0;
    waitCyc(10);
    curSp = 16'h1FFE;
    retnStb = 1; instrEnd = 1; waitCyc(1); retnStb = 0; instrEnd = 0;
    waitCyc(1);
    chk("R10", "return served first", busy, 1);
    waitCyc(16);
    curPc = 16'h7788; curSp = 16'h2000;
    instrEnd = 1; waitCyc(1); instrEnd = 0;
    waitCyc(1);
    chk("R10", "pending edge taken", busy, 1);
    waitCyc(14);
    finishRun();
  end

endmodule